// File: doc/BRIEF.md
# Privileged-Call Trap Routing Unit

This unit sits next to an instruction decoder. The decoder hands it one decoded request at a time. A request is either a secure-monitor call or an access (read or write) to a system-control coprocessor register. With the request come the current exception level (0 = user, 1 = operating system, 2 = hypervisor, 3 = secure monitor) and the configuration controls that govern routing.

For every valid request the unit picks exactly one outcome:

- run the access locally;
- trap it to a higher level;
- raise an undefined-instruction exception.

The decision is registered. One cycle after the request, the unit emits a single-cycle exception pulse. The pulse carries the target level, a 6-bit class code and a 16-bit syndrome. When the access runs locally, the unit emits a single-cycle local-completion pulse instead.

Priority when conditions overlap: an undefined condition wins over any trap condition. A monitor call's immediate never affects routing. For coprocessor accesses, a 16-entry trap mask selects which registers trap to the hypervisor. The mask is indexed by the primary register number (CRn).

Top module: `trap_router`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset with no request, excValid and localDone are 0. excTarget, excClass and excSyndrome are also 0.
- R2: Each cycle with reqValid=1 produces, on the next cycle only, exactly one of excValid=1 or localDone=1. A cycle with reqValid=0 produces neither on the next cycle.
- R3: A monitor call (reqKind=0) at level 0 gives excValid with class 0x00 (undefined) and target level 1.
- R4: A monitor call at level 1, 2 or 3 while secCfg bit 7 is 1 gives class 0x00 with target equal to the current level. This holds even when hypTrapCall=1.
- R5: A monitor call at level 1, with secCfg bit 7 equal to 0 and hypTrapCall=1, gives class 0x13 with target level 2.
- R6: A monitor call with secCfg bit 7 equal to 0 gives class 0x13 with target level 3 in these cases: at level 1 with hypTrapCall=0, and at level 2 or 3 regardless of hypTrapCall. The other bits of secCfg have no effect.
- R7: For a routed monitor call, excSyndrome[3:0] equals callImm and excSyndrome[15:4] is 0. callImm never changes target or class.
- R8: A coprocessor access (reqKind=1) with cpCoproc other than 4'b1111 gives class 0x00. The target is level 1 when issued at level 0, otherwise the current level.
- R9: A coprocessor access with cpCoproc=4'b1111 at level 0 gives class 0x00 with target level 1.
- R10: A coprocessor access with cpCoproc=4'b1111 traps when all of these hold: it is issued at level 1, level2Enabled=1, and hypRegTrap[cpCrn]=1. The result is class 0x04 with target level 2. The syndrome is {1'b0, opc2[2:0], opc1[2:0], CRn[3:0], CRm[3:0], isRead}, with bit 0 = isRead.
- R11: Any other coprocessor access with cpCoproc=4'b1111 executes locally: localDone=1 and excValid=0.
- R12: Every undefined outcome (class 0x00) carries excSyndrome = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 1 | 0 = monitor call, 1 = coprocessor register access |
| curLevel | input | 2 | Exception level of the issuing code |
| callImm | input | 4 | Monitor-call immediate |
| cpCoproc | input | 4 | Coprocessor number field |
| cpOpc1 | input | 3 | First opcode field |
| cpCrn | input | 4 | Primary register number |
| cpCrm | input | 4 | Secondary register number |
| cpOpc2 | input | 3 | Second opcode field |
| cpIsRead | input | 1 | 1 = register read, 0 = register write |
| secCfg | input | 8 | Secure configuration byte; bit 7 disables monitor calls |
| hypTrapCall | input | 1 | Hypervisor control: route level-1 monitor calls to level 2 |
| level2Enabled | input | 1 | Hypervisor level is active |
| hypRegTrap | input | 16 | Per-CRn hypervisor trap mask for coprocessor accesses |
| excValid | output | 1 | Single-cycle exception request |
| excTarget | output | 2 | Target exception level |
| excClass | output | 6 | Exception class code |
| excSyndrome | output | 16 | Captured immediate or register encoding |
| localDone | output | 1 | Single-cycle pulse: access executed locally |

## Verification
The assertions assume that reqValid is never unknown after reset. They also assume that every request field is valid and steady in the cycle reqValid is high, since each property ties one request cycle to the following output cycle. The bench drives all inputs on the falling edge and holds a request for exactly one cycle. It then inserts an idle cycle, so each outcome pulse and its return to zero are seen apart from the next request. The bench sweeps every combination of level, disable bit, hypervisor controls and immediate for monitor calls. For coprocessor accesses it sweeps every level, CRn and enable setting, with the trap mask set either to a single matching bit or to every bit except the matching one.

// File: rtl/trap_router_pkg.sv
`timescale 1ns/1ps
package trap_router_pkg;
  localparam int LVL_W   = 2;
  localparam int CLS_W   = 6;
  localparam int IMM_W   = 4;
  localparam int CP_W    = 4;
  localparam int CRN_W   = 4;
  localparam int CRM_W   = 4;
  localparam int OPC_W   = 3;
  localparam int SCFG_W  = 8;
  localparam int MON_DIS_BIT = 7;
  localparam int NUM_REG = 1 << CRN_W;
  localparam int SYN_W   = 1 + CRM_W + CRN_W + 2 * OPC_W + 1;

  localparam logic [CLS_W-1:0] CLS_UNDEF   = 6'h00;
  localparam logic [CLS_W-1:0] CLS_CPTRAP  = 6'h04;
  localparam logic [CLS_W-1:0] CLS_MONCALL = 6'h13;
  localparam logic [CP_W-1:0]  CP_SYSCTL   = 4'hF;

  typedef enum logic {REQ_CALL = 1'b0, REQ_COPROC = 1'b1} reqKind_e;

  typedef struct packed {
    logic             undef;
    logic             cpTrap;
    logic             monCall;
    logic             runLocal;
    logic [LVL_W-1:0] target;
  } ctrlStrobe_t;
endpackage

// File: rtl/trap_router_ctrl.sv
`timescale 1ns/1ps
module trap_router_ctrl
  import trap_router_pkg::*;
(
  input  logic               reqValid,
  input  logic               reqKind,
  input  logic [LVL_W-1:0]   curLevel,
  input  logic [CP_W-1:0]    cpCoproc,
  input  logic [CRN_W-1:0]   cpCrn,
  input  logic               monDisable,
  input  logic               hypTrapCall,
  input  logic               level2Enabled,
  input  logic [NUM_REG-1:0] hypRegTrap,
  output ctrlStrobe_t        strobe
);
  logic [NUM_REG-1:0] regHit;
  logic               regTrapHit;
  logic [LVL_W-1:0]   undefTarget;
  logic               atUser;
  logic               atKernel;

  // one comparator per trappable register number
  for (genvar g = 0; g < NUM_REG; g++) begin : g_regHit
    assign regHit[g] = (cpCrn == CRN_W'(g)) && hypRegTrap[g];
  end

  assign regTrapHit  = |regHit;
  assign atUser      = (curLevel == LVL_W'(0));
  assign atKernel    = (curLevel == LVL_W'(1));
  assign undefTarget = atUser ? LVL_W'(1) : curLevel;

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      if (reqKind == REQ_CALL) begin
        if (atUser || monDisable) begin
          strobe.undef  = 1'b1;
          strobe.target = undefTarget;
        end else if (atKernel && hypTrapCall) begin
          strobe.monCall = 1'b1;
          strobe.target  = LVL_W'(2);
        end else begin
          strobe.monCall = 1'b1;
          strobe.target  = LVL_W'(3);
        end
      end else begin
        if ((cpCoproc != CP_SYSCTL) || atUser) begin
          strobe.undef  = 1'b1;
          strobe.target = undefTarget;
        end else if (atKernel && level2Enabled && regTrapHit) begin
          strobe.cpTrap = 1'b1;
          strobe.target = LVL_W'(2);
        end else begin
          strobe.runLocal = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trap_router_dp.sv
`timescale 1ns/1ps
module trap_router_dp
  import trap_router_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobe_t        strobe,
  input  logic [IMM_W-1:0]   callImm,
  input  logic [OPC_W-1:0]   cpOpc1,
  input  logic [CRN_W-1:0]   cpCrn,
  input  logic [CRM_W-1:0]   cpCrm,
  input  logic [OPC_W-1:0]   cpOpc2,
  input  logic               cpIsRead,
  output logic               excValid,
  output logic [LVL_W-1:0]   excTarget,
  output logic [CLS_W-1:0]   excClass,
  output logic [SYN_W-1:0]   excSyndrome,
  output logic               localDone
);
  logic [SYN_W-1:0] nextSyn;
  logic [CLS_W-1:0] nextCls;
  logic             nextFire;

  assign nextFire = strobe.undef | strobe.cpTrap | strobe.monCall;

  always_comb begin
    nextSyn = '0;
    nextCls = CLS_UNDEF;
    if (strobe.monCall) begin
      nextCls = CLS_MONCALL;
      nextSyn = SYN_W'(callImm);
    end else if (strobe.cpTrap) begin
      nextCls = CLS_CPTRAP;
      nextSyn = {1'b0, cpOpc2, cpOpc1, cpCrn, cpCrm, cpIsRead};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      excValid    <= 1'b0;
      excTarget   <= '0;
      excClass    <= '0;
      excSyndrome <= '0;
      localDone   <= 1'b0;
    end else begin
      excValid    <= nextFire;
      excTarget   <= nextFire ? strobe.target : '0;
      excClass    <= nextFire ? nextCls : '0;
      excSyndrome <= nextFire ? nextSyn : '0;
      localDone   <= strobe.runLocal;
    end
  end
endmodule

// File: rtl/trap_router.sv
`timescale 1ns/1ps
module trap_router
  import trap_router_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic               reqKind,
  input  logic [LVL_W-1:0]   curLevel,
  input  logic [IMM_W-1:0]   callImm,
  input  logic [CP_W-1:0]    cpCoproc,
  input  logic [OPC_W-1:0]   cpOpc1,
  input  logic [CRN_W-1:0]   cpCrn,
  input  logic [CRM_W-1:0]   cpCrm,
  input  logic [OPC_W-1:0]   cpOpc2,
  input  logic               cpIsRead,
  input  logic [SCFG_W-1:0]  secCfg,
  input  logic               hypTrapCall,
  input  logic               level2Enabled,
  input  logic [NUM_REG-1:0] hypRegTrap,
  output logic               excValid,
  output logic [LVL_W-1:0]   excTarget,
  output logic [CLS_W-1:0]   excClass,
  output logic [SYN_W-1:0]   excSyndrome,
  output logic               localDone
);
  ctrlStrobe_t strobe;

  trap_router_ctrl u_ctrl (
    .reqValid     (reqValid),
    .reqKind      (reqKind),
    .curLevel     (curLevel),
    .cpCoproc     (cpCoproc),
    .cpCrn        (cpCrn),
    .monDisable   (secCfg[MON_DIS_BIT]),
    .hypTrapCall  (hypTrapCall),
    .level2Enabled(level2Enabled),
    .hypRegTrap   (hypRegTrap),
    .strobe       (strobe)
  );

  trap_router_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .callImm    (callImm),
    .cpOpc1     (cpOpc1),
    .cpCrn      (cpCrn),
    .cpCrm      (cpCrm),
    .cpOpc2     (cpOpc2),
    .cpIsRead   (cpIsRead),
    .excValid   (excValid),
    .excTarget  (excTarget),
    .excClass   (excClass),
    .excSyndrome(excSyndrome),
    .localDone  (localDone)
  );
endmodule

// File: rtl/trap_router_chk.sv
`timescale 1ns/1ps
module trap_router_chk
  import trap_router_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reqValid,
  input logic               reqKind,
  input logic [LVL_W-1:0]   curLevel,
  input logic [SCFG_W-1:0]  secCfg,
  input logic               hypTrapCall,
  input logic               excValid,
  input logic [LVL_W-1:0]   excTarget,
  input logic [CLS_W-1:0]   excClass,
  input logic [SYN_W-1:0]   excSyndrome,
  input logic               localDone
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!excValid && !localDone));

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> (excValid ^ localDone));

  a_r3_user_call_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == REQ_CALL && curLevel == LVL_W'(0))
      |=> (excValid && excClass == CLS_UNDEF && excTarget == LVL_W'(1)));

  a_r4_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == REQ_CALL && curLevel != LVL_W'(0) && secCfg[MON_DIS_BIT])
      |=> (excValid && excClass == CLS_UNDEF));

  a_r5_hyp_route: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == REQ_CALL && curLevel == LVL_W'(1) &&
     !secCfg[MON_DIS_BIT] && hypTrapCall)
      |=> (excValid && excClass == CLS_MONCALL && excTarget == LVL_W'(2)));

  a_r9_user_coproc_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == REQ_COPROC && curLevel == LVL_W'(0))
      |=> (excValid && excClass == CLS_UNDEF));

  a_r10_cptrap_level: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && excClass == CLS_CPTRAP) |-> (excTarget == LVL_W'(2)));

  a_r12_undef_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && excClass == CLS_UNDEF) |-> (excSyndrome == '0));
endmodule

bind trap_router trap_router_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reqValid   (reqValid),
  .reqKind    (reqKind),
  .curLevel   (curLevel),
  .secCfg     (secCfg),
  .hypTrapCall(hypTrapCall),
  .excValid   (excValid),
  .excTarget  (excTarget),
  .excClass   (excClass),
  .excSyndrome(excSyndrome),
  .localDone  (localDone)
);

// File: tb/trap_router_tb.sv
`timescale 1ns/1ps
module trap_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqKind = 1'b0;
  logic [1:0]  curLevel = '0;
  logic [3:0]  callImm = '0;
  logic [3:0]  cpCoproc = '0;
  logic [2:0]  cpOpc1 = '0;
  logic [3:0]  cpCrn = '0;
  logic [3:0]  cpCrm = '0;
  logic [2:0]  cpOpc2 = '0;
  logic        cpIsRead = 1'b0;
  logic [7:0]  secCfg = '0;
  logic        hypTrapCall = 1'b0;
  logic        level2Enabled = 1'b0;
  logic [15:0] hypRegTrap = '0;
  logic        excValid;
  logic [1:0]  excTarget;
  logic [5:0]  excClass;
  logic [15:0] excSyndrome;
  logic        localDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trap_router u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
    .curLevel(curLevel), .callImm(callImm), .cpCoproc(cpCoproc),
    .cpOpc1(cpOpc1), .cpCrn(cpCrn), .cpCrm(cpCrm), .cpOpc2(cpOpc2),
    .cpIsRead(cpIsRead), .secCfg(secCfg), .hypTrapCall(hypTrapCall),
    .level2Enabled(level2Enabled), .hypRegTrap(hypRegTrap),
    .excValid(excValid), .excTarget(excTarget), .excClass(excClass),
    .excSyndrome(excSyndrome), .localDone(localDone)
  );

  task automatic checkOut(input string req, input logic eV, input logic [1:0] eT,
                          input logic [5:0] eC, input logic [15:0] eS, input logic eL);
    nChecks++;
    if (excValid !== eV || excTarget !== eT || excClass !== eC ||
        excSyndrome !== eS || localDone !== eL) begin
      nFails++;
      $display("FAIL %s: got v=%0b t=%0d c=%h s=%h l=%0b, expected v=%0b t=%0d c=%h s=%h l=%0b",
               req, excValid, excTarget, excClass, excSyndrome, localDone,
               eV, eT, eC, eS, eL);
    end
  endtask

  // drive one request, check its outcome, then check the idle cycle after it
  task automatic applyReq(input string req, input logic eV, input logic [1:0] eT,
                          input logic [5:0] eC, input logic [15:0] eS, input logic eL);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkOut(req, eV, eT, eC, eS, eL);
    @(negedge clk);
    checkOut("R2 pulse ends", 1'b0, 2'd0, 6'h00, 16'h0, 1'b0);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    checkOut("R1 in reset", 1'b0, 2'd0, 6'h00, 16'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 1'b0, 2'd0, 6'h00, 16'h0, 1'b0);
    @(negedge clk);
    checkOut("R2 idle", 1'b0, 2'd0, 6'h00, 16'h0, 1'b0);

    // monitor calls: R3 R4 R5 R6 R7 R12
    for (int lvl = 0; lvl < 4; lvl++)
      for (int dis = 0; dis < 2; dis++)
        for (int hyp = 0; hyp < 2; hyp++)
          for (int imm = 0; imm < 16; imm++) begin
            logic [1:0] t;
            logic [5:0] c;
            logic [15:0] s;
            string r;
            reqKind = 1'b0;
            curLevel = 2'(lvl);
            callImm = 4'(imm);
            secCfg = {1'(dis), 7'(imm * 5 + lvl)};
            hypTrapCall = 1'(hyp);
            level2Enabled = 1'(imm & 1);
            hypRegTrap = 16'(imm * 16'h1357);
            cpCoproc = 4'(imm);
            if (lvl == 0) begin
              t = 2'd1; c = 6'h00; s = 16'h0; r = "R3 user call";
            end else if (dis == 1) begin
              t = 2'(lvl); c = 6'h00; s = 16'h0; r = "R4 disabled call";
            end else if (lvl == 1 && hyp == 1) begin
              t = 2'd2; c = 6'h13; s = 16'(imm); r = "R5 hyp route / R7 imm";
            end else begin
              t = 2'd3; c = 6'h13; s = 16'(imm); r = "R6 monitor route / R7 imm";
            end
            @(negedge clk);
            applyReq(r, 1'b1, t, c, s, 1'b0);
          end

    // coprocessor accesses: R8 R9 R10 R11 R12
    for (int sel = 0; sel < 2; sel++)
      for (int lvl = 0; lvl < 4; lvl++)
        for (int en = 0; en < 2; en++)
          for (int crn = 0; crn < 16; crn++)
            for (int mhit = 0; mhit < 2; mhit++) begin
              logic [3:0] cp;
              logic [2:0] o1, o2;
              logic [3:0] cm;
              logic rd;
              logic [15:0] m;
              cp = (sel == 1) ? 4'hF : ((crn == 15) ? 4'hE : 4'(crn));
              o1 = 3'(crn);
              cm = ~4'(crn);
              o2 = 3'(crn + lvl);
              rd = 1'(crn ^ mhit);
              m = (16'h1 << crn);
              if (mhit == 0) m = ~m;
              reqKind = 1'b1;
              curLevel = 2'(lvl);
              cpCoproc = cp;
              cpOpc1 = o1; cpCrn = 4'(crn); cpCrm = cm; cpOpc2 = o2; cpIsRead = rd;
              level2Enabled = 1'(en);
              hypRegTrap = m;
              hypTrapCall = 1'(crn & 1);
              secCfg = 8'(crn * 37);
              callImm = 4'(~crn);
              @(negedge clk);
              if (cp != 4'hF)
                applyReq("R8 other coprocessor", 1'b1, (lvl == 0) ? 2'd1 : 2'(lvl),
                         6'h00, 16'h0, 1'b0);
              else if (lvl == 0)
                applyReq("R9 user coprocessor", 1'b1, 2'd1, 6'h00, 16'h0, 1'b0);
              else if (lvl == 1 && en == 1 && mhit == 1)
                applyReq("R10 coprocessor trap", 1'b1, 2'd2, 6'h04,
                         {1'b0, o2, o1, 4'(crn), cm, rd}, 1'b0);
              else
                applyReq("R11 local execute", 1'b0, 2'd0, 6'h00, 16'h0, 1'b1);
            end

    // back-to-back requests: R2 one outcome per request cycle
    reqKind = 1'b0; curLevel = 2'd2; secCfg = 8'h00; callImm = 4'd9;
    @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    checkOut("R2 back-to-back first", 1'b1, 2'd3, 6'h13, 16'd9, 1'b0);
    reqKind = 1'b1; cpCoproc = 4'hF; curLevel = 2'd3;
    @(negedge clk);
    reqValid = 1'b0;
    checkOut("R2 back-to-back second", 1'b0, 2'd0, 6'h00, 16'h0, 1'b1);
    @(negedge clk);
    checkOut("R2 back-to-back drain", 1'b0, 2'd0, 6'h00, 16'h0, 1'b0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule